// File: doc/BRIEF.md
# Ballast Mode Sequencer

This block is the top-level operating-mode controller of a lamp ballast. It steps through four modes: undervoltage lockout, frequency sweep (preheat and ignition), run, and a latched fault. Its inputs are two supply comparator flags, the digitized oscillator control word, a crest-factor fault flag and an external shutdown flag. From the current mode it drives the half-bridge enable, the enables for zero-voltage-switching correction and crest-factor protection, a clear for the control word, and an enable for the minimum-frequency reference.

The supply flags come from comparators in another clock domain, so each passes through two synchronizer flops before the state logic uses it. The control word, the crest-factor fault and the shutdown flag are synchronous to the block clock. A fault latches the bridge off. The only way out of a fault is for the supply to fall below the lower threshold and then rise above the upper one.

Top module: `ballast_mode_seq`

## Requirements
- R1: After reset the mode is undervoltage (code 00), `bridge_en`, `zvs_en`, `cf_en` and `fmin_ref_en` are 0, and `cw_clear` is 1.
- R2: In undervoltage mode the block moves to sweep mode when the synchronized supply-high flag is 1 and the synchronized supply-low flag is 0. A change on `sup_hi_a` takes effect on the third rising clock edge after it. When both flags are 1, the block stays in undervoltage mode.
- R3: In sweep mode (code 01), `bridge_en` and `fmin_ref_en` are 1 and `zvs_en`, `cf_en` and `cw_clear` are 0. `cf_fault` and `sd_req` have no effect in this mode.
- R4: In sweep mode, a `ctrl_word` strictly greater than `RUN_LVL` (default 204) moves the block to run mode on the next clock edge. A value equal to `RUN_LVL` or below it leaves the block in sweep mode.
- R5: In run mode (code 10), `bridge_en`, `fmin_ref_en`, `zvs_en` and `cf_en` are 1 and `cw_clear` is 0.
- R6: In run mode, any of the following moves the block to fault mode on the next clock edge: `cf_fault` = 1, `sd_req` = 1, or a `ctrl_word` strictly below `SD_LVL` (default 35). A value equal to `SD_LVL` or above it keeps the block in run mode.
- R7: In fault mode (code 11), `bridge_en`, `zvs_en`, `cf_en` and `fmin_ref_en` are 0 and `cw_clear` is 1. While the synchronized supply-low flag is 0, the block stays in fault mode whatever `sup_hi_a`, `ctrl_word`, `cf_fault` and `sd_req` do.
- R8: From any mode, a synchronized supply-low flag of 1 returns the block to undervoltage mode on the next edge. This return takes priority over every other transition. A change on `sup_lo_a` takes effect on the third edge after it.
- R9: Run mode is entered only from sweep mode, and fault mode is entered only from run mode or from fault mode itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_hi_a | input | 1 | Supply above the rising threshold (asynchronous) |
| sup_lo_a | input | 1 | Supply below the falling threshold (asynchronous) |
| ctrl_word | input | CW_W | Digitized oscillator control word |
| cf_fault | input | 1 | Crest-factor fault flag |
| sd_req | input | 1 | External shutdown flag |
| mode | output | 2 | Mode code: 00 undervoltage, 01 sweep, 10 run, 11 fault |
| bridge_en | output | 1 | Half-bridge switching enable |
| zvs_en | output | 1 | Zero-voltage-switching correction enable |
| cf_en | output | 1 | Crest-factor protection enable |
| cw_clear | output | 1 | Hold the control word at zero |
| fmin_ref_en | output | 1 | Minimum-frequency reference enable |

## Verification
The bench sweeps every control-word value both on the entry to run mode and in run mode, so it catches a comparison that is off by one in either direction. A design with `>=` in place of `>` would enter run mode at exactly 204, and one with `<=` in place of `<` would fault at exactly 35. The bench counts clock edges across the synchronizer: a design with one flop too few or too many would change mode a cycle early or late. The bench also drives supply-low and crest-factor fault in the same cycle; a design that put the fault ahead of the supply would land in fault mode instead of undervoltage. It checks that fault mode holds while the other inputs toggle, and that a fault flag in sweep mode has no effect; a design that leaked either would leave fault mode or trip early.

// File: rtl/ballast_mode_seq.sv
module ballast_mode_seq #(
  parameter int CW_W    = 8,
  parameter int RUN_LVL = 204,
  parameter int SD_LVL  = 35
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sup_hi_a,
  input  logic            sup_lo_a,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic            cf_fault,
  input  logic            sd_req,
  output logic [1:0]      mode,
  output logic            bridge_en,
  output logic            zvs_en,
  output logic            cf_en,
  output logic            cw_clear,
  output logic            fmin_ref_en
);
  localparam logic [1:0] M_UV = 2'b00, M_SWP = 2'b01, M_RUN = 2'b10, M_FLT = 2'b11;
  localparam logic [CW_W-1:0] RUN_W = CW_W'(RUN_LVL);
  localparam logic [CW_W-1:0] SD_W  = CW_W'(SD_LVL);

  logic [1:0] hi_sync, lo_sync;
  logic       hi_s, lo_s;
  logic [1:0] st, st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_sync <= 2'b00;
      lo_sync <= 2'b00;
    end else begin
      hi_sync <= {hi_sync[0], sup_hi_a};
      lo_sync <= {lo_sync[0], sup_lo_a};
    end

  assign hi_s = hi_sync[1];
  assign lo_s = lo_sync[1];

  always_comb begin
    st_nx = st;
    if (lo_s) st_nx = M_UV;
    else
      case (st)
        M_UV:  if (hi_s) st_nx = M_SWP;
        M_SWP: if (ctrl_word > RUN_W) st_nx = M_RUN;
        M_RUN: if (cf_fault || sd_req || ctrl_word < SD_W) st_nx = M_FLT;
        default: st_nx = M_FLT;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= M_UV;
    else        st <= st_nx;

  assign mode        = st;
  assign bridge_en   = (st == M_SWP) || (st == M_RUN);
  assign fmin_ref_en = bridge_en;
  assign zvs_en      = (st == M_RUN);
  assign cf_en       = (st == M_RUN);
  assign cw_clear    = !bridge_en;

  // R8
  supply_low_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_s |=> (mode == M_UV));

  // R7
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FLT && !lo_s) |=> (mode == M_FLT));

  // R2
  uv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UV && !hi_s) |=> (mode == M_UV));

  // R4
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SWP && !lo_s && ctrl_word > RUN_W) |=> (mode == M_RUN));

  // R6
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && !lo_s && (cf_fault || sd_req)) |=> (mode == M_FLT));

  // R9
  run_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN) |-> ($past(mode) == M_SWP || $past(mode) == M_RUN));

  // R3
  drive_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en != cw_clear);
endmodule

// File: tb/ballast_mode_seq_bench.sv
module ballast_mode_seq_bench;
  logic clk = 0, rst_n = 0;
  logic sup_hi_a = 0, sup_lo_a = 0, cf_fault = 0, sd_req = 0;
  logic [7:0] ctrl_word = 0;
  logic [1:0] mode;
  logic bridge_en, zvs_en, cf_en, cw_clear, fmin_ref_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ballast_mode_seq u_ballast_mode_seq (
    .clk(clk), .rst_n(rst_n), .sup_hi_a(sup_hi_a), .sup_lo_a(sup_lo_a),
    .ctrl_word(ctrl_word), .cf_fault(cf_fault), .sd_req(sd_req), .mode(mode),
    .bridge_en(bridge_en), .zvs_en(zvs_en), .cf_en(cf_en), .cw_clear(cw_clear),
    .fmin_ref_en(fmin_ref_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic int outs();
    return {bridge_en, zvs_en, cf_en, cw_clear, fmin_ref_en};
  endfunction

  task automatic to_uv();
    sup_hi_a = 0; sup_lo_a = 1; cf_fault = 0; sd_req = 0; ctrl_word = 0;
    step(3);
    sup_lo_a = 0;
    step(2);
  endtask

  task automatic to_sweep();
    to_uv();
    sup_hi_a = 1;
    step(3);
  endtask

  task automatic to_run();
    to_sweep();
    ctrl_word = 8'd255;
    step(1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    done = 1;
  end

  initial begin
    step(2);
    // R1 reset state: bridge,zvs,cf,clear,fmin = 0,0,0,1,0 -> 5'b00010
    chk("R1 mode", mode, 0);
    chk("R1 outputs", outs(), 5'b00010);
    rst_n = 1;
    step(1);

    // R2 synchronizer latency
    to_uv();
    sup_hi_a = 1;
    step(2);
    chk("R2 still uv after two edges", mode, 0);
    step(1);
    chk("R2 sweep after three edges", mode, 1);
    // R3 sweep outputs 5'b10001
    chk("R3 outputs", outs(), 5'b10001);
    cf_fault = 1; sd_req = 1;
    step(2);
    chk("R3 faults ignored in sweep", mode, 1);
    cf_fault = 0; sd_req = 0;

    // R2 both flags high hold uv
    to_uv();
    sup_hi_a = 1; sup_lo_a = 1;
    step(5);
    chk("R2 both flags stay uv", mode, 0);

    // R4 sweep of every control word
    for (int v = 0; v < 256; v++) begin
      to_sweep();
      ctrl_word = 8'(v);
      step(1);
      chk($sformatf("R4 cw=%0d", v), mode, (v > 204) ? 2 : 1);
    end

    // R5 run outputs 5'b11101
    to_run();
    chk("R5 mode", mode, 2);
    chk("R5 outputs", outs(), 5'b11101);

    // R6 sweep of every control word in run
    for (int v = 0; v < 256; v++) begin
      to_run();
      ctrl_word = 8'(v);
      step(1);
      chk($sformatf("R6 cw=%0d", v), mode, (v < 35) ? 3 : 2);
    end
    to_run();
    ctrl_word = 8'd100; cf_fault = 1;
    step(1);
    chk("R6 crest fault", mode, 3);
    to_run();
    ctrl_word = 8'd100; sd_req = 1;
    step(1);
    chk("R6 shutdown flag", mode, 3);

    // R7 fault outputs 5'b00010 and stickiness
    chk("R7 outputs", outs(), 5'b00010);
    sd_req = 0; ctrl_word = 8'd255; sup_hi_a = 0;
    step(4);
    sup_hi_a = 1; ctrl_word = 8'd0; cf_fault = 1;
    step(4);
    chk("R7 fault held", mode, 3);

    // R8 exit from fault via supply low
    cf_fault = 0; sup_lo_a = 1;
    step(2);
    chk("R8 fault before sync", mode, 3);
    step(1);
    chk("R8 fault to uv", mode, 0);

    // R8 priority over crest fault in run
    to_run();
    ctrl_word = 8'd100; sup_lo_a = 1;
    step(2);
    chk("R8 run before sync", mode, 2);
    cf_fault = 1;
    step(1);
    chk("R8 priority over fault", mode, 0);
    cf_fault = 0;

    // R8 from sweep
    to_sweep();
    sup_lo_a = 1;
    step(3);
    chk("R8 sweep to uv", mode, 0);

    // R9 no direct uv to run
    to_uv();
    ctrl_word = 8'd255; sup_hi_a = 1;
    step(3);
    chk("R9 uv goes to sweep not run", mode, 1);
    step(1);
    chk("R9 then run", mode, 2);

    done = 1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule